// File: doc/BRIEF.md
# Split Capture Timer/Counter

This block is a 16-bit timer/counter built from two 8-bit halves that can run on their own or be chained into one wide counter. A timer half advances once per wrap of its own programmable prescaler. An event half advances once per rising edge of a synchronized external event input. Each half counts up to a programmed match value, returns to zero on the following step and raises a one-cycle request flag for that half.

A 2-bit mode field chooses one of four arrangements:
- two prescaled 8-bit timers;
- a prescaled 8-bit timer in the low half with an 8-bit event counter in the high half;
- one prescaled 16-bit timer;
- one 16-bit event counter.

Two capture strobes, one per half, are synchronized and edge-detected. Each copies the live count into a capture register whose width follows the chosen mode. Configuration is loaded through a small write port with a 3-bit address.

Top module: `split_capture_timer`

## Requirements
- R1: While reset is asserted and right after it, both counts, both capture registers and both flags read zero.
- R2: Address 0 holds the mode in data bits [1:0]: 0 = two 8-bit timers, 1 = low timer plus high event counter, 2 = 16-bit timer, 3 = 16-bit event counter. A write to address 0 clears both counts and both prescalers at that same clock edge.
- R3: A timer half steps once every PR+1 clock cycles. PR is its 8-bit prescaler value: address 3 for the low half and address 4 for the high half. The 16-bit timer is paced by the low prescaler.
- R4: Match values sit at address 1 (low) and address 2 (high). A step taken while a half's count equals its match value loads zero instead of incrementing. The same edge raises that half's flag for exactly one cycle.
- R5: In modes 2 and 3 the halves form one count {high,low} that wraps against the combined match {address 2, address 1}. Only the high flag can rise; the low flag stays low.
- R6: The event input passes two synchronizing flops. Each rising edge is counted once, at the third clock edge that samples it high. A level held high counts only once.
- R7: A capture strobe's rising edge, seen at the third sampling edge, copies the count as it stood before that edge. In modes 0 and 1 the low strobe loads the low capture and the high strobe loads the high capture. In modes 2 and 3 either strobe loads the full 16-bit count into both.
- R8: Writes to the match or prescaler addresses take effect on the following step and do not clear the running count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 3 | Configuration address (0 mode, 1/2 match, 3/4 prescaler) |
| wr_data | input | DATA_W (8) | Configuration write data |
| evt_in | input | 1 | External event input, asynchronous |
| cap_lo_in | input | 1 | Low capture strobe, asynchronous |
| cap_hi_in | input | 1 | High capture strobe, asynchronous |
| cnt_lo | output | HALF_W (8) | Live low count |
| cnt_hi | output | HALF_W (8) | Live high count |
| cap_lo | output | HALF_W (8) | Low capture register |
| cap_hi | output | HALF_W (8) | High capture register |
| flag_lo | output | 1 | Low-half match request, one-cycle pulse |
| flag_hi | output | 1 | High-half or combined match request, one-cycle pulse |

## Verification
Both counts are outputs, so a prescaler or count that goes wrong shows as a mismatch in the very cycle after the bad step. A wrong synchronizer depth or edge detector shows as an event or capture landing one cycle early or late, or counted twice for a long high level. A missed carry or a bad combined match in the 16-bit modes shows in the high count, or as a stray low flag, no later than the step where the low half rolls over. A capture routed to the wrong half is seen at the next strobe, so strobes are issued in every mode with the counts at differing values.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    MODE_DUAL8 = 2'd0,
    MODE_T8_E8 = 2'd1,
    MODE_T16   = 2'd2,
    MODE_E16   = 2'd3
  } tmr_mode_e;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] REG_MODE     = 3'd0;
  localparam logic [ADDR_W-1:0] REG_MATCH_LO = 3'd1;
  localparam logic [ADDR_W-1:0] REG_MATCH_HI = 3'd2;
  localparam logic [ADDR_W-1:0] REG_PRE_LO   = 3'd3;
  localparam logic [ADDR_W-1:0] REG_PRE_HI   = 3'd4;

  function automatic logic is_wide(tmr_mode_e m);
    return m[1];
  endfunction

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);

  logic [STAGES-1:0] chain_q, chain_d;
  logic              prev_q, prev_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], din};
    prev_d  = chain_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= prev_d;
    end
  end

  assign rise = chain_q[STAGES-1] & ~prev_q;

  // R6: one input edge gives one detected pulse, never two in a row
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic [PRE_W-1:0] reload,
  output logic             tick
);

  logic [PRE_W-1:0] pc_q, pc_d;
  logic             at_end;

  always_comb begin
    at_end = (pc_q >= reload);
    if (clr || !en) begin
      pc_d = '0;
    end else if (at_end) begin
      pc_d = '0;
    end else begin
      pc_d = pc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else begin
      pc_q <= pc_d;
    end
  end

  assign tick = en & ~clr & at_end;

  // R3: a disabled prescaler holds at zero
  a_r3_idle_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!en) |-> (pc_q == '0));

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
  import tmr_pkg::*;
#(
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tmr_mode_e         mode,
  input  logic              clr,
  input  logic              tick_lo,
  input  logic              tick_hi,
  input  logic              evt_rise,
  input  logic [HALF_W-1:0] match_lo,
  input  logic [HALF_W-1:0] match_hi,
  output logic [HALF_W-1:0] cnt_lo,
  output logic [HALF_W-1:0] cnt_hi,
  output logic              flag_lo,
  output logic              flag_hi
);

  localparam int WIDE_W = 2 * HALF_W;

  logic [HALF_W-1:0] lo_q, lo_d, hi_q, hi_d;
  logic              flo_q, flo_d, fhi_q, fhi_d;
  logic              step_lo, step_hi, step_w, wide;
  logic              lo_hit, hi_hit;
  logic [WIDE_W-1:0] wide_inc;

  always_comb begin
    wide    = is_wide(mode);
    step_lo = 1'b0;
    step_hi = 1'b0;
    step_w  = 1'b0;
    case (mode)
      MODE_DUAL8: begin step_lo = tick_lo; step_hi = tick_hi;  end
      MODE_T8_E8: begin step_lo = tick_lo; step_hi = evt_rise; end
      MODE_T16:   step_w = tick_lo;
      MODE_E16:   step_w = evt_rise;
      default:    step_w = 1'b0;
    endcase
  end

  always_comb begin
    lo_hit   = (lo_q == match_lo);
    hi_hit   = (hi_q == match_hi);
    wide_inc = {hi_q, lo_q} + 1'b1;
    lo_d     = lo_q;
    hi_d     = hi_q;
    flo_d    = 1'b0;
    fhi_d    = 1'b0;
    if (clr) begin
      lo_d = '0;
      hi_d = '0;
    end else if (wide) begin
      if (step_w) begin
        if (lo_hit && hi_hit) begin
          lo_d  = '0;
          hi_d  = '0;
          fhi_d = 1'b1;
        end else begin
          {hi_d, lo_d} = wide_inc;
        end
      end
    end else begin
      if (step_lo) begin
        if (lo_hit) begin
          lo_d  = '0;
          flo_d = 1'b1;
        end else begin
          lo_d = lo_q + 1'b1;
        end
      end
      if (step_hi) begin
        if (hi_hit) begin
          hi_d  = '0;
          fhi_d = 1'b1;
        end else begin
          hi_d = hi_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= '0;
      flo_q <= 1'b0;
      fhi_q <= 1'b0;
    end else begin
      lo_q  <= lo_d;
      hi_q  <= hi_d;
      flo_q <= flo_d;
      fhi_q <= fhi_d;
    end
  end

  assign cnt_lo  = lo_q;
  assign cnt_hi  = hi_q;
  assign flag_lo = flo_q;
  assign flag_hi = fhi_q;

  // R4: a raised flag always sits on a half that has just returned to zero
  a_r4_lo_flag_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    flag_lo |-> (lo_q == '0));

  // R4: same for the high half; in wide modes the whole count is zero
  a_r4_hi_flag_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    flag_hi |-> (hi_q == '0) && (!is_wide(mode) || lo_q == '0));

  // R5: no low request while a wide mode has been held for two cycles
  a_r5_no_lo_flag_wide: assert property (@(posedge clk) disable iff (!rst_n)
    (is_wide(mode) && $past(is_wide(mode))) |-> !flag_lo);

  // R3: the low count only moves up by one or back to zero
  a_r3_lo_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_q != $past(lo_q)) |-> ((lo_q == $past(lo_q) + 1'b1) || (lo_q == '0)));

endmodule

// File: rtl/tmr_capture.sv
module tmr_capture #(
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide,
  input  logic              pulse_lo,
  input  logic              pulse_hi,
  input  logic [HALF_W-1:0] live_lo,
  input  logic [HALF_W-1:0] live_hi,
  output logic [HALF_W-1:0] cap_lo,
  output logic [HALF_W-1:0] cap_hi
);

  logic [HALF_W-1:0] lo_q, lo_d, hi_q, hi_d;
  logic              take_lo, take_hi;

  always_comb begin
    take_lo = wide ? (pulse_lo | pulse_hi) : pulse_lo;
    take_hi = wide ? (pulse_lo | pulse_hi) : pulse_hi;
    lo_d    = take_lo ? live_lo : lo_q;
    hi_d    = take_hi ? live_hi : hi_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign cap_lo = lo_q;
  assign cap_hi = hi_q;

  // R7: the low capture register changes only after a strobe that owns it
  a_r7_lo_cap_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_q != $past(lo_q)) |-> $past(pulse_lo || (wide && pulse_hi)));

  // R7: the high capture register likewise
  a_r7_hi_cap_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_q != $past(hi_q)) |-> $past(pulse_hi || (wide && pulse_lo)));

endmodule

// File: rtl/split_capture_timer.sv
module split_capture_timer
  import tmr_pkg::*;
#(
  parameter int HALF_W   = 8,
  parameter int PRE_W    = 8,
  parameter int SYNC_LEN = 2,
  localparam int DATA_W  = (HALF_W > PRE_W) ? HALF_W : PRE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              evt_in,
  input  logic              cap_lo_in,
  input  logic              cap_hi_in,
  output logic [HALF_W-1:0] cnt_lo,
  output logic [HALF_W-1:0] cnt_hi,
  output logic [HALF_W-1:0] cap_lo,
  output logic [HALF_W-1:0] cap_hi,
  output logic              flag_lo,
  output logic              flag_hi
);

  localparam int N_SYNC = 3;
  localparam int N_PRE  = 2;

  // configuration registers
  tmr_mode_e         mode_q, mode_d;
  logic [HALF_W-1:0] mlo_q, mlo_d, mhi_q, mhi_d;
  logic [PRE_W-1:0]  pre_q [N_PRE];
  logic [PRE_W-1:0]  pre_d [N_PRE];
  logic              clr;

  always_comb begin
    clr      = wr_en && (wr_addr == REG_MODE);
    mode_d   = mode_q;
    mlo_d    = mlo_q;
    mhi_d    = mhi_q;
    pre_d[0] = pre_q[0];
    pre_d[1] = pre_q[1];
    if (wr_en) begin
      case (wr_addr)
        REG_MODE:     mode_d   = tmr_mode_e'(wr_data[1:0]);
        REG_MATCH_LO: mlo_d    = wr_data[HALF_W-1:0];
        REG_MATCH_HI: mhi_d    = wr_data[HALF_W-1:0];
        REG_PRE_LO:   pre_d[0] = wr_data[PRE_W-1:0];
        REG_PRE_HI:   pre_d[1] = wr_data[PRE_W-1:0];
        default:      mode_d   = mode_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MODE_DUAL8;
      mlo_q    <= '0;
      mhi_q    <= '0;
      pre_q[0] <= '0;
      pre_q[1] <= '0;
    end else begin
      mode_q   <= mode_d;
      mlo_q    <= mlo_d;
      mhi_q    <= mhi_d;
      pre_q[0] <= pre_d[0];
      pre_q[1] <= pre_d[1];
    end
  end

  // input synchronizers and edge detectors: bit 0 event, 1 low strobe, 2 high strobe
  logic [N_SYNC-1:0] raw_in, rise;
  assign raw_in = {cap_hi_in, cap_lo_in, evt_in};

  for (genvar gs = 0; gs < N_SYNC; gs++) begin : g_sync
    tmr_edge_sync #(.STAGES(SYNC_LEN)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw_in[gs]),
      .rise (rise[gs])
    );
  end

  // prescalers: index 0 low half (also paces the 16-bit timer), 1 high half
  logic [N_PRE-1:0] pre_en, tick;
  assign pre_en[0] = (mode_q != MODE_E16);
  assign pre_en[1] = (mode_q == MODE_DUAL8);

  for (genvar gp = 0; gp < N_PRE; gp++) begin : g_pre
    tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (pre_en[gp]),
      .clr   (clr),
      .reload(pre_q[gp]),
      .tick  (tick[gp])
    );
  end

  logic [HALF_W-1:0] live_lo, live_hi;

  tmr_count_core #(.HALF_W(HALF_W)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode_q),
    .clr     (clr),
    .tick_lo (tick[0]),
    .tick_hi (tick[1]),
    .evt_rise(rise[0]),
    .match_lo(mlo_q),
    .match_hi(mhi_q),
    .cnt_lo  (live_lo),
    .cnt_hi  (live_hi),
    .flag_lo (flag_lo),
    .flag_hi (flag_hi)
  );

  tmr_capture #(.HALF_W(HALF_W)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .wide    (is_wide(mode_q)),
    .pulse_lo(rise[1]),
    .pulse_hi(rise[2]),
    .live_lo (live_lo),
    .live_hi (live_hi),
    .cap_lo  (cap_lo),
    .cap_hi  (cap_hi)
  );

  assign cnt_lo = live_lo;
  assign cnt_hi = live_hi;

  // R2: a mode write leaves both counts at zero on the next cycle
  a_r2_mode_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_lo == '0) && (cnt_hi == '0));

endmodule

// File: tb/tb_split_capture_timer.sv
module tb_split_capture_timer;

  localparam int CLK_PERIOD = 10;
  localparam int HW   = 8;
  localparam int HMOD = 1 << HW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en;
  logic [2:0]    wr_addr;
  logic [HW-1:0] wr_data;
  logic          evt_in, cap_lo_in, cap_hi_in;
  logic [HW-1:0] cnt_lo, cnt_hi, cap_lo, cap_hi;
  logic          flag_lo, flag_hi;

  always #(CLK_PERIOD/2) clk = ~clk;

  split_capture_timer dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .evt_in(evt_in), .cap_lo_in(cap_lo_in), .cap_hi_in(cap_hi_in),
    .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .cap_lo(cap_lo), .cap_hi(cap_hi),
    .flag_lo(flag_lo), .flag_hi(flag_hi)
  );

  int    checks = 0;
  int    failures = 0;
  bit    done = 0;
  string tag = "R1";

  // reference model state
  int m, ml, mh, prl, prh, pl, ph, cl, ch, kl, kh, fl, fh;
  int e1, e2, e3, l1, l2, l3, h1, h2, h3;

  task automatic chk(input string rq, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m = 0; ml = 0; mh = 0; prl = 0; prh = 0; pl = 0; ph = 0;
      cl = 0; ch = 0; kl = 0; kh = 0; fl = 0; fh = 0;
      e1 = 0; e2 = 0; e3 = 0; l1 = 0; l2 = 0; l3 = 0; h1 = 0; h2 = 0; h3 = 0;
    end else begin
      int er, rl, rh, clr, tl, th, wide, v, step;
      er = (e2 == 1 && e3 == 0);
      rl = (l2 == 1 && l3 == 0);
      rh = (h2 == 1 && h3 == 0);
      clr  = (wr_en && wr_addr == 0);
      wide = (m >= 2);
      tl = 0; th = 0;
      if (clr || m == 3) pl = 0;
      else if (pl >= prl) begin pl = 0; tl = 1; end
      else pl++;
      if (clr || m != 0) ph = 0;
      else if (ph >= prh) begin ph = 0; th = 1; end
      else ph++;
      if (wide) begin
        if (rl || rh) begin kl = cl; kh = ch; end
      end else begin
        if (rl) kl = cl;
        if (rh) kh = ch;
      end
      fl = 0; fh = 0;
      if (clr) begin
        cl = 0; ch = 0;
      end else if (wide) begin
        step = (m == 2) ? tl : er;
        if (step) begin
          v = ch * HMOD + cl;
          if (v == mh * HMOD + ml) begin v = 0; fh = 1; end
          else v = (v + 1) % (HMOD * HMOD);
          cl = v % HMOD; ch = v / HMOD;
        end
      end else begin
        step = (m == 0) ? th : er;
        if (tl) begin
          if (cl == ml) begin cl = 0; fl = 1; end else cl = (cl + 1) % HMOD;
        end
        if (step) begin
          if (ch == mh) begin ch = 0; fh = 1; end else ch = (ch + 1) % HMOD;
        end
      end
      e3 = e2; e2 = e1; e1 = int'(evt_in);
      l3 = l2; l2 = l1; l1 = int'(cap_lo_in);
      h3 = h2; h2 = h1; h1 = int'(cap_hi_in);
      if (wr_en) begin
        case (wr_addr)
          3'd0: m   = int'(wr_data[1:0]);
          3'd1: ml  = int'(wr_data);
          3'd2: mh  = int'(wr_data);
          3'd3: prl = int'(wr_data);
          3'd4: prh = int'(wr_data);
          default: ;
        endcase
      end
    end
  end

  // compare against the model on every cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(tag, "cnt_lo",  int'(cnt_lo),  cl);
      chk(tag, "cnt_hi",  int'(cnt_hi),  ch);
      chk(tag, "cap_lo",  int'(cap_lo),  kl);
      chk(tag, "cap_hi",  int'(cap_hi),  kh);
      chk(tag, "flag_lo", int'(flag_lo), fl);
      chk(tag, "flag_hi", int'(flag_hi), fh);
    end
  end

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = HW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic evt_pulse(input int hi_cyc, input int lo_cyc);
    evt_in = 1'b1; repeat (hi_cyc) @(negedge clk);
    evt_in = 1'b0; repeat (lo_cyc) @(negedge clk);
  endtask

  task automatic strobe(input bit hi_side, input int len);
    if (hi_side) cap_hi_in = 1'b1; else cap_lo_in = 1'b1;
    repeat (len) @(negedge clk);
    cap_hi_in = 1'b0; cap_lo_in = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    evt_in = 1'b0; cap_lo_in = 1'b0; cap_hi_in = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1", "cnt_lo reset", int'(cnt_lo), 0);
    chk("R1", "cnt_hi reset", int'(cnt_hi), 0);
    chk("R1", "cap_lo reset", int'(cap_lo), 0);
    chk("R1", "cap_hi reset", int'(cap_hi), 0);
    chk("R1", "flags reset",  int'({flag_hi, flag_lo}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3: two prescaled 8-bit timers, different prescale rates
    tag = "R3";
    wr(3, 2); wr(4, 0); wr(1, 4); wr(2, 3);
    repeat (40) @(negedge clk);

    // R4: match of zero wraps every step; then a large match
    tag = "R4";
    wr(1, 0); wr(2, 200);
    repeat (30) @(negedge clk);

    // R8: reprogram match and prescaler while counting
    tag = "R8";
    wr(1, 9); wr(3, 0); wr(4, 1);
    repeat (30) @(negedge clk);

    // R2: mode write clears both counts in the next cycle
    tag = "R2";
    wr(0, 1);
    chk("R2", "cnt_lo after mode write", int'(cnt_lo), 0);
    chk("R2", "cnt_hi after mode write", int'(cnt_hi), 0);

    // R6: low timer plus high event counter
    tag = "R6";
    wr(2, 4);
    evt_pulse(1, 3); evt_pulse(3, 2); evt_pulse(12, 1);
    for (int i = 0; i < 6; i++) evt_pulse(2, 2);
    repeat (4) @(negedge clk);

    // R7: separate captures in an 8-bit mode
    tag = "R7";
    strobe(1'b0, 1); repeat (5) @(negedge clk);
    evt_pulse(1, 2); strobe(1'b1, 4); strobe(1'b0, 2);
    repeat (5) @(negedge clk);

    // R5: 16-bit timer, combined match 0x0103
    tag = "R5";
    wr(0, 2); wr(3, 0); wr(1, 3); wr(2, 1);
    repeat (290) @(negedge clk);
    strobe(1'b1, 1);
    repeat (50) @(negedge clk);
    strobe(1'b0, 1);

    // R5/R6: 16-bit event counter, combined match 0x0006
    tag = "R5";
    wr(0, 3); wr(2, 0); wr(1, 6);
    for (int i = 0; i < 16; i++) evt_pulse(1 + (i % 3), 2);
    tag = "R7";
    strobe(1'b0, 1); evt_pulse(2, 2); strobe(1'b1, 1);
    repeat (6) @(negedge clk);

    // R2: back to dual 8-bit timers after a wide mode
    tag = "R2";
    wr(0, 0);
    chk("R2", "cnt_lo after return to mode 0", int'(cnt_lo), 0);
    repeat (20) @(negedge clk);

    finish_run();
  end

endmodule